// File: doc/BRIEF.md
# Serial Slave Bitstream Loader

This block lets an external microcontroller push a configuration bitstream into a configuration memory over a plain serial link. The link has a clock, an active-low select and one data line. The loader samples the data line on each rising serial clock edge while it is selected. It slides a 32-bit window over the incoming bits until the window equals a synchronization word, and this can happen at any bit alignment. After that match, it packs every following 32 bits into one word and presents the word on a write port with a ready handshake.

A single status output reports the outcome in an open-drain manner: high means released, low means driven low. A complete load leaves the pin released and raises `done_o`. If select goes away before all expected words have been written, the bitstream is invalid: the pin goes low for a fixed 1.5 µs, and the loader then resumes its search. If the memory does not accept a word within a bounded number of cycles, that is a load error: the pin stays low until reset.

The serial inputs are asynchronous and pass through synchronizers. The system clock only needs to be at least four times the serial clock rate. There is no lower limit on the serial clock rate.

Top module: `cfg_loader`

## Requirements
- R1: While and after reset, `status_o` is 1, `done_o` is 0 and `mem_we_o` is 0.
- R2: A bit is taken from `sdi_i` on each rising edge of `sck_i` while `cs_ni` is 0 (mode 0, idle clock low). Bits are shifted most significant first. Any serial clock whose high and low phases each last at least two system clocks is accepted.
- R3: Payload starts only after the last 32 received bits equal `SYNC_WORD` (default 32'hA5C3_5A3C). The match works at any bit offset, and bits before the match are discarded.
- R4: Deasserting `cs_ni` during the search clears the partly filled window, so a sync word split across a deselect is not matched.
- R5: After the match, each group of 32 bits is written as one word at addresses 0, 1, 2 and so on. `mem_we_o` stays high with `mem_addr_o` and `mem_wdata_o` stable until a cycle in which `mem_ready_i` is 1.
- R6: When `NUM_WORDS` writes have been accepted, `done_o` becomes 1 and `status_o` stays 1. Later serial bits cause no write until reset.
- R7: If `cs_ni` goes high after the match with fewer than `NUM_WORDS` words accepted, `status_o` is 0 for exactly `PULSE_NS` (1.5 µs = 300 cycles at 200 MHz) and then returns to 1. A partial word is dropped, `done_o` stays 0, and the search for the sync word starts again.
- R8: If a write waits `TIMEOUT_CYC` cycles without `mem_ready_i`, the write is dropped, `status_o` stays 0 and no further write occurs until reset, whatever the serial inputs do.
- R9: Before a match, no write occurs, and releasing `cs_ni` does not pulse `status_o`.
- R10: Serial clock edges while `cs_ni` is 1 carry no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| cs_ni | input | 1 | Active-low select, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| mem_we_o | output | 1 | Write request to configuration memory |
| mem_addr_o | output | ADDR_W | Word address of the write |
| mem_wdata_o | output | WORD_W | Word data of the write |
| mem_ready_i | input | 1 | Memory accepts the pending write |
| status_o | output | 1 | Status pin level: 1 released, 0 driven low |
| done_o | output | 1 | Load completed |

## Verification
The main load is driven with the sync word placed at three offsets: no leading bits, 5 junk bits and 13 junk bits. A window fixed to byte or word boundaries would miss the odd offsets. Memory acceptance is tried both at once and after a ten-cycle stall. This separates correct holding of address and data from a port that moves on before the handshake. Two failure sequences are run: an early deselect, which must give exactly one 300-cycle low pulse followed by a clean reload, and a memory that never accepts, which must leave the pin low for good. These tell the two failure reports apart. A sync word split by a deselect, traffic sent while deselected, and traffic sent after completion must all produce no write and no pulse.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_DONE   = 3'd2,
    ST_STROBE = 3'd3,
    ST_FAULT  = 3'd4
  } ld_state_e;

  function automatic int unsigned ns_to_cycles(input int unsigned clk_hz, input int unsigned ns);
    return ((clk_hz / 1_000_000) * ns) / 1000;
  endfunction
endpackage

// File: rtl/cfg_spi_front.sv
module cfg_spi_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic sel_o
);
  logic [SYNC_STAGES:0]   sck_q;
  logic [SYNC_STAGES-1:0] sdi_q;
  logic [SYNC_STAGES-1:0] cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      sdi_q <= '0;
      cs_q  <= '1;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-1:0], sck_i};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdi_i};
      cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_ni};
    end
  end

  assign sel_o     = ~cs_q[SYNC_STAGES-1];
  assign bit_o     = sdi_q[SYNC_STAGES-1];
  assign bit_vld_o = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES] & sel_o;

  // sck must be at least 4x slower than clk: a rising edge is never seen twice in a row
  assert_single_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);
  // R10: no sample while deselected
  assert_no_bit_unselected_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> !bit_vld_o);
endmodule

// File: rtl/cfg_word_asm.sv
module cfg_word_asm #(
  parameter int unsigned     WORD_W    = 32,
  parameter logic [WORD_W-1:0] SYNC_WORD = 32'hA5C3_5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              sel_i,
  input  logic              hunt_i,
  input  logic              load_i,
  output logic              sync_hit_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned FILL_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WORD_W);
  localparam logic [FILL_W-1:0] FILL_ARM = FILL_W'(WORD_W - 1);

  logic [WORD_W-1:0] win_q, word_q;
  logic [WORD_W-1:0] win_nxt;
  logic [FILL_W-1:0] fill_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              vld_q;

  assign win_nxt = {win_q[WORD_W-2:0], bit_i};

  // window search (R3, R4)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (!sel_i || !hunt_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld_i) begin
      win_q  <= win_nxt;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign sync_hit_o = bit_vld_i & sel_i & hunt_i & (fill_q >= FILL_ARM) & (win_nxt == SYNC_WORD);

  // word packing (R5)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!sel_i || !load_i) begin
        cnt_q <= '0;
      end else if (bit_vld_i) begin
        word_q <= {word_q[WORD_W-2:0], bit_i};
        if (cnt_q == LAST_BIT) begin
          cnt_q <= '0;
          vld_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;

  assert_word_after_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(load_i));
  assert_hit_only_hunting_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_hit_o |-> hunt_i && !load_i);
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned NUM_WORDS   = 4,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned PULSE_CYC   = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sync_hit_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              mem_ready_i,
  output logic              hunt_o,
  output logic              load_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              status_o,
  output logic              done_o
);
  localparam int unsigned CNT_W   = $clog2(NUM_WORDS + 1);
  localparam int unsigned WAIT_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned PULSE_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0]   LAST_WORD  = CNT_W'(NUM_WORDS - 1);
  localparam logic [WAIT_W-1:0]  WAIT_LAST  = WAIT_W'(TIMEOUT_CYC - 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(PULSE_CYC - 1);

  ld_state_e          state_q;
  logic               we_q, status_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [WORD_W-1:0]  wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      we_q     <= 1'b0;
      status_q <= 1'b1;
      cnt_q    <= '0;
      wait_q   <= '0;
      pulse_q  <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (sync_hit_i) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
          end
        end
        ST_LOAD: begin
          if (word_vld_i) begin
            we_q    <= 1'b1;
            wdata_q <= word_i;
            wait_q  <= '0;
          end else if (we_q) begin
            if (mem_ready_i) begin
              we_q  <= 1'b0;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST_WORD) state_q <= ST_DONE;
            end else if (wait_q == WAIT_LAST) begin
              we_q     <= 1'b0;
              status_q <= 1'b0;
              state_q  <= ST_FAULT;
            end else begin
              wait_q <= wait_q + 1'b1;
            end
          end else if (!sel_i) begin
            // short bitstream: fixed-width strobe
            status_q <= 1'b0;
            pulse_q  <= '0;
            state_q  <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (pulse_q == PULSE_LAST) begin
            status_q <= 1'b1;
            state_q  <= ST_HUNT;
          end else begin
            pulse_q <= pulse_q + 1'b1;
          end
        end
        ST_DONE:  ;
        ST_FAULT: ;
        default:  state_q <= ST_HUNT;
      endcase
    end
  end

  assign hunt_o      = (state_q == ST_HUNT);
  assign load_o      = (state_q == ST_LOAD);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = cnt_q[ADDR_W-1:0];
  assign mem_wdata_o = wdata_q;
  assign status_o    = status_q;
  assign done_o      = (state_q == ST_DONE);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !mem_ready_i && wait_q != WAIT_LAST) |=> we_q && $stable(mem_addr_o) && $stable(mem_wdata_o));
  assert_addr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> cnt_q < CNT_W'(NUM_WORDS));
  assert_no_overrun_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_i |-> !we_q);
  assert_done_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && status_o && !mem_we_o);
  assert_strobe_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && pulse_q == PULSE_LAST) |=> state_q == ST_HUNT && status_o);
  assert_strobe_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STROBE |-> !status_o && !done_o);
  assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FAULT |=> state_q == ST_FAULT && !status_o && !mem_we_o);
  assert_write_in_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> state_q == ST_LOAD);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned       CLK_HZ      = 200_000_000,
  parameter int unsigned       PULSE_NS    = 1500,
  parameter int unsigned       WORD_W      = 32,
  parameter logic [WORD_W-1:0] SYNC_WORD   = 32'hA5C3_5A3C,
  parameter int unsigned       NUM_WORDS   = 4,
  parameter int unsigned       TIMEOUT_CYC = 64,
  parameter int unsigned       SYNC_STAGES = 2,
  localparam int unsigned      ADDR_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  output logic              status_o,
  output logic              done_o
);
  localparam int unsigned PULSE_CYC = ns_to_cycles(CLK_HZ, PULSE_NS);

  logic              bit_vld, bit_val, sel;
  logic              hunt, load, sync_hit, word_vld;
  logic [WORD_W-1:0] word;

  cfg_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .sdi_i,
    .bit_vld_o(bit_vld), .bit_o(bit_val), .sel_o(sel)
  );

  cfg_word_asm #(.WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)) u_asm (
    .clk_i, .rst_ni,
    .bit_vld_i(bit_vld), .bit_i(bit_val), .sel_i(sel),
    .hunt_i(hunt), .load_i(load),
    .sync_hit_o(sync_hit), .word_vld_o(word_vld), .word_o(word)
  );

  cfg_load_fsm #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
    .TIMEOUT_CYC(TIMEOUT_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .sel_i(sel),
    .sync_hit_i(sync_hit), .word_vld_i(word_vld), .word_i(word),
    .mem_ready_i, .hunt_o(hunt), .load_o(load),
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .status_o, .done_o
  );

  assert_reset_idle_R1: assert property (@(posedge clk_i) !rst_ni |=> status_o && !done_o && !mem_we_o);
endmodule

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  localparam logic [31:0] SYNC = 32'hA5C3_5A3C;
  localparam int NW = 4;
  localparam int PULSE = 300;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_ni = 1'b1, sdi = 1'b0;
  logic mem_we, mem_ready, status, done;
  logic [1:0]  mem_addr;
  logic [31:0] mem_wdata;

  logic ready_on = 1'b1;
  int   ready_dly = 0;
  int   wait_cnt = 0;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;
  bit   low_seen = 0;
  string cur_req = "R5";
  logic [1:0]  exp_addr[$];
  logic [31:0] exp_data[$];

  always #2.5 clk = ~clk;

  cfg_loader uut (
    .clk_i(clk), .rst_ni, .sck_i(sck), .cs_ni, .sdi_i(sdi),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .status_o(status), .done_o(done)
  );

  assign mem_ready = ready_on && mem_we && (wait_cnt >= ready_dly);
  always @(posedge clk) wait_cnt <= (!mem_we || mem_ready) ? 0 : wait_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !status) low_seen <= 1'b1;
    if (rst_ni && mem_we && mem_ready) begin
      if (exp_addr.size() == 0) begin
        chk(0, cur_req, "unexpected write", {30'd0, mem_addr}, 32'hx);
      end else begin
        logic [1:0]  ea;
        logic [31:0] ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(mem_addr == ea, "R5", "write address", {30'd0, mem_addr}, {30'd0, ea});
        chk(mem_wdata == ed, "R2/R5", "write data", mem_wdata, ed);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      cyc(4);
      sck = 1'b1;
      cyc(4);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_ni = 1'b0;
    cyc(4);
  endtask

  task automatic desel();
    cyc(4);
    cs_ni = 1'b1;
    cyc(8);
  endtask

  task automatic send_payload(input int n, input logic [31:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      w = seed ^ (32'h1357_9BDF * (k + 1));
      exp_addr.push_back(2'(k));
      exp_data.push_back(w);
      send_bits(w, 32);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cs_ni = 1'b1; sck = 1'b0; sdi = 1'b0;
    ready_on = 1'b1; ready_dly = 0;
    exp_addr.delete(); exp_data.delete();
    cyc(3);
    rst_ni = 1'b1;
    cyc(3);
    low_seen = 1'b0;
  endtask

  task automatic full_load(input logic [31:0] junk, input int njunk, input logic [31:0] seed);
    sel();
    if (njunk > 0) send_bits(junk, njunk);
    send_bits(SYNC, 32);
    send_payload(NW, seed);
    desel();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lw;
    // R1: reset state
    cyc(2);
    chk(status == 1'b1 && done == 1'b0 && mem_we == 1'b0, "R1", "in reset",
        {29'd0, status, done, mem_we}, 32'h4);
    do_reset();
    chk(status == 1'b1 && done == 1'b0 && mem_we == 1'b0, "R1", "after reset",
        {29'd0, status, done, mem_we}, 32'h4);

    // R3: aligned sync, immediate ready
    cur_req = "R3";
    full_load(32'h0, 0, 32'hDEAD_0001);
    chk(exp_addr.size() == 0, "R5", "pending expected writes", exp_addr.size(), 0);
    chk(done == 1'b1, "R6", "done after full load", {31'd0, done}, 1);
    chk(status == 1'b1 && !low_seen, "R6", "status released", {31'd0, status}, 1);

    // R6: traffic after done is ignored
    cur_req = "R6";
    sel(); send_bits(SYNC, 32); send_bits(32'hFFFF_0000, 32); send_bits(32'h1234_5678, 32); desel();
    cyc(20);
    chk(done == 1'b1 && status == 1'b1, "R6", "done sticky", {30'd0, done, status}, 3);

    // R3: sync after 5 junk bits, R5: stalled ready
    do_reset();
    cur_req = "R3";
    ready_dly = 10;
    full_load(32'h0000_0015, 5, 32'h0BAD_F00D);
    chk(exp_addr.size() == 0, "R5", "writes with stall", exp_addr.size(), 0);
    chk(done == 1'b1 && status == 1'b1, "R5", "done with stall", {30'd0, done, status}, 3);

    // R3: sync after 13 junk bits
    do_reset();
    full_load(32'h0000_1ACE, 13, 32'h7777_AAAA);
    chk(exp_addr.size() == 0 && done == 1'b1, "R3", "odd offset load", {31'd0, done}, 1);

    // R10: bits while deselected; R9: words without sync
    do_reset();
    cur_req = "R10";
    send_bits(SYNC, 32); send_bits(32'h1111_2222, 32);
    cyc(10);
    chk(mem_we == 1'b0, "R10", "no write while deselected", {31'd0, mem_we}, 0);
    cur_req = "R9";
    sel(); send_bits(32'h3333_4444, 32); send_bits(32'h5555_6666, 32); desel();
    cyc(400);
    chk(!low_seen && status == 1'b1, "R9", "no pulse before sync", {31'd0, low_seen}, 0);
    chk(done == 1'b0 && mem_we == 1'b0, "R9", "no write before sync", {30'd0, done, mem_we}, 0);

    // R4: sync split by deselect
    cur_req = "R4";
    sel(); send_bits(SYNC[31:16], 16); desel();
    sel(); send_bits(SYNC[15:0], 16); send_bits(32'h9999_8888, 32); desel();
    cyc(400);
    chk(!low_seen && done == 1'b0, "R4", "split sync not matched", {31'd0, low_seen}, 0);

    // R7: early deselect gives one fixed pulse, then recovery
    do_reset();
    cur_req = "R7";
    sel(); send_bits(SYNC, 32); send_payload(2, 32'hC0DE_0000); send_bits(32'h5, 7);
    cyc(4); cs_ni = 1'b1;
    lw = 0;
    while (status == 1'b1 && lw < 100) begin cyc(1); lw++; end
    chk(status == 1'b0, "R7", "pulse started", {31'd0, status}, 0);
    lw = 0;
    while (status == 1'b0 && lw < 2000) begin cyc(1); lw++; end
    chk(lw == PULSE, "R7", "pulse width cycles", lw, PULSE);
    chk(done == 1'b0 && exp_addr.size() == 0, "R7", "no done after pulse", {31'd0, done}, 0);
    cyc(20);
    chk(status == 1'b1, "R7", "single pulse", {31'd0, status}, 1);
    full_load(32'h0, 0, 32'h4242_4242);
    chk(done == 1'b1 && exp_addr.size() == 0, "R7", "reload after pulse", {31'd0, done}, 1);

    // R8: write timeout holds status low
    do_reset();
    cur_req = "R8";
    ready_on = 1'b0;
    sel(); send_bits(SYNC, 32); send_bits(32'hAAAA_5555, 32);
    cyc(200);
    chk(status == 1'b0 && mem_we == 1'b0, "R8", "timeout fault", {30'd0, status, mem_we}, 0);
    ready_on = 1'b1;
    send_bits(32'h0F0F_0F0F, 32); send_bits(SYNC, 32); send_bits(32'h1, 32); desel();
    cyc(600);
    chk(status == 1'b0 && done == 1'b0, "R8", "fault sticky", {30'd0, status, done}, 0);
    chk(exp_addr.size() == 0, "R8", "no writes after fault", exp_addr.size(), 0);

    finish_run();
  end
endmodule